// File: doc/BRIEF.md
# Loop Replay Instruction Front End

This block is the fetch and decode front end of a small in-order processor. It saves switching power inside hardware loops. Each cycle it fetches one instruction word from program memory, registers it, decodes it into a wide control word, and passes that word to the execute stage. When a loop begins, the block records each decoded control word of the body during the first pass. For every later pass it holds fetch and decode idle and feeds execute from that local store in the original order.

The program side marks the first body word with a loop-start pulse. The pulse carries the body length L and the pass count N. A loop qualifies for replay when 1 <= L <= DEPTH and N >= 2. Any other loop is executed by fetching its body again on every pass, and the block changes nothing. When the last replayed pass ends, fetch resumes in the next cycle with the word after the loop. The execute stage sees one unbroken stream of control words.

Top module: `loop_replay_frontend`

## Requirements
- R1: While reset is high, fetch_en reads 1, and decode_en, ctrl_valid and from_buffer read 0.
- R2: A word fetched in cycle c (fetch_en high, instr_in presented) appears on ctrl_out in cycle c+3 with ctrl_valid high. ctrl_out[27:16] equals instr[11:0], and ctrl_out[15:0] is the one-hot code of instr[15:12] (bit k set for value k).
- R3: For a qualifying loop, fetch_en drops in the cycle after the L-th body word is fetched. It stays low for exactly (N-1)*L consecutive cycles. The block never stores more than L words for one loop.
- R4: decode_en equals the value fetch_en had one cycle earlier, so decode is idle for the same number of cycles as fetch.
- R5: For a qualifying loop, the ctrl_out stream is the decoded body repeated N times in fetch order. from_buffer is 0 for the first pass and 1 for each replayed word.
- R6: After the final replayed pass, fetch_en is high again in the next cycle. Once ctrl_valid has gone high after reset, it never drops.
- R7: A loop with L greater than DEPTH, or with N of 1, causes no gating and no replay. fetch_en stays high, from_buffer stays 0, and the stream follows the words supplied.
- R8: A loop-start pulse is ignored during the first pass of a qualifying loop and while fetch is gated. The gating length and the output stream stay as set by the loop in progress.
- R9: The boundary body lengths L = 1 and L = DEPTH replay correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_start | input | 1 | Marks the word on instr_in as the first body word of a loop |
| loop_len | input | 5 | Loop body length L |
| loop_count | input | 16 | Total pass count N |
| instr_in | input | 16 | Instruction word from program memory, valid whenever fetch_en is high |
| fetch_en | output | 1 | Fetch stage enable, low while passes are replayed |
| decode_en | output | 1 | Decode stage enable |
| ctrl_out | output | 28 | Decoded control word toward execute |
| ctrl_valid | output | 1 | ctrl_out carries a word |
| from_buffer | output | 1 | ctrl_out came from the replay store rather than the live decoder |

## Verification
The assertions assume that program memory returns a word in every cycle fetch_en is high. They also assume that a loop-start pulse comes only with the first word of a body, and that a qualifying loop's body is not fetched a second time. The bench acts as program memory and meets these assumptions by construction. It presents the body once for qualifying loops and N times for the others. It raises stray loop-start pulses only in the windows where the block must ignore them. Loop lengths and pass counts are drawn so that both qualifying and non-qualifying loops occur, next to directed cases at the length boundaries.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_CAP  = 2'd1,
    ST_GATE = 2'd2
  } lb_state_e;
endpackage

// File: rtl/lb_loop_ctrl.sv
module lb_loop_ctrl
  import lb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int OFF_W = CNT_W + LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loop_start,
  input  logic [LEN_W-1:0] loop_len,
  input  logic [CNT_W-1:0] loop_count,
  output logic             fetch_en,
  output logic             accept,
  output logic             cap_tag,
  output logic             last_tag,
  output logic [LEN_W-1:0] len_q,
  output logic [CNT_W-1:0] cnt_q
);
  lb_state_e        state;
  logic [LEN_W-1:0] cap_left;
  logic [OFF_W-1:0] off_left;
  logic [OFF_W-1:0] gate_len;
  logic             eligible;

  // a loop qualifies when its body fits the store and it repeats
  assign eligible = (loop_len != '0) && (loop_len <= LEN_W'(DEPTH)) &&
                    (loop_count > CNT_W'(1));
  assign accept   = (state == ST_RUN) && loop_start && eligible;
  assign cap_tag  = accept || (state == ST_CAP);
  assign last_tag = (accept && (loop_len == LEN_W'(1))) ||
                    ((state == ST_CAP) && (cap_left == LEN_W'(1)));
  assign gate_len = OFF_W'(loop_count - 1'b1) * OFF_W'(loop_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      fetch_en <= 1'b1;
      cap_left <= '0;
      off_left <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (accept) begin
            len_q    <= loop_len;
            cnt_q    <= loop_count;
            off_left <= gate_len;
            if (loop_len == LEN_W'(1)) begin
              fetch_en <= 1'b0;
              state    <= ST_GATE;
            end else begin
              cap_left <= loop_len - 1'b1;
              state    <= ST_CAP;
            end
          end
        end
        ST_CAP: begin
          if (cap_left == LEN_W'(1)) begin
            fetch_en <= 1'b0;
            state    <= ST_GATE;
          end else begin
            cap_left <= cap_left - 1'b1;
          end
        end
        ST_GATE: begin
          if (off_left == OFF_W'(1)) begin
            fetch_en <= 1'b1;
            state    <= ST_RUN;
          end else begin
            off_left <= off_left - 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/lb_fetch_stage.sv
module lb_fetch_stage #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_en,
  input  logic [IW-1:0] instr_in,
  input  logic          cap_tag,
  input  logic          last_tag,
  output logic [IW-1:0] word_q,
  output logic          valid_q,
  output logic          cap_q,
  output logic          last_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cap_q   <= 1'b0;
      last_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= fetch_en;
      if (fetch_en) begin
        word_q <= instr_in;
        cap_q  <= cap_tag;
        last_q <= last_tag;
      end else begin
        cap_q  <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lb_decode_stage.sv
module lb_decode_stage #(
  parameter int IW    = 16,
  parameter int OPC_W = 4,
  localparam int FLD_W = IW - OPC_W,
  localparam int UNITS = 2 ** OPC_W,
  localparam int CW    = FLD_W + UNITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [IW-1:0] word,
  output logic [CW-1:0] dec_w,
  output logic [CW-1:0] dec_q,
  output logic          dec_v
);
  logic [OPC_W-1:0] opc;
  logic [UNITS-1:0] unit_sel;

  assign opc = word[IW-1 -: OPC_W];

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign unit_sel[u] = (opc == OPC_W'(u));
  end

  assign dec_w = {word[FLD_W-1:0], unit_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_v <= 1'b0;
      dec_q <= '0;
    end else begin
      dec_v <= in_v;
      if (in_v) dec_q <= dec_w;
    end
  end
endmodule

// File: rtl/lb_replay_buf.sv
module lb_replay_buf #(
  parameter int DEPTH = 16,
  parameter int CW    = 28,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             we,
  input  logic             we_last,
  input  logic [CW-1:0]    wdata,
  input  logic [LEN_W-1:0] len_q,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CW-1:0]    rd_q,
  output logic             rd_v,
  output logic             rd_act,
  output logic             buf_valid,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr
);
  logic [CW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] riter;

  // storage: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
    if (rd_act) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      riter     <= '0;
      rd_act    <= 1'b0;
      rd_v      <= 1'b0;
      buf_valid <= 1'b0;
    end else begin
      rd_v <= rd_act;
      if (clear) begin
        wptr      <= '0;
        buf_valid <= 1'b0;
      end else if (we) begin
        wptr <= wptr + 1'b1;
      end
      if (we && we_last) begin
        buf_valid <= 1'b1;
        rd_act    <= 1'b1;
        rptr      <= '0;
        riter     <= cnt_q - 1'b1;
      end else if (rd_act) begin
        if (LEN_W'(rptr) == len_q - 1'b1) begin
          rptr <= '0;
          if (riter == CNT_W'(1)) rd_act <= 1'b0;
          else                    riter  <= riter - 1'b1;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lb_out_sel.sv
module lb_out_sel #(
  parameter int CW = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_v,
  input  logic [CW-1:0] rd_q,
  input  logic          dec_v,
  input  logic [CW-1:0] dec_q,
  output logic [CW-1:0] ctrl_out,
  output logic          ctrl_valid,
  output logic          from_buffer
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_out    <= '0;
      ctrl_valid  <= 1'b0;
      from_buffer <= 1'b0;
    end else begin
      ctrl_valid  <= rd_v | dec_v;
      from_buffer <= rd_v;
      if (rd_v)       ctrl_out <= rd_q;
      else if (dec_v) ctrl_out <= dec_q;
    end
  end
endmodule

// File: rtl/loop_replay_frontend.sv
module loop_replay_frontend #(
  parameter int IW    = 16,
  parameter int OPC_W = 4,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = (IW - OPC_W) + 2 ** OPC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loop_start,
  input  logic [LEN_W-1:0] loop_len,
  input  logic [CNT_W-1:0] loop_count,
  input  logic [IW-1:0]    instr_in,
  output logic             fetch_en,
  output logic             decode_en,
  output logic [CW-1:0]    ctrl_out,
  output logic             ctrl_valid,
  output logic             from_buffer
);
  logic             accept, cap_tag, last_tag;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IW-1:0]    fq_word;
  logic             fq_cap, fq_last;
  logic [CW-1:0]    dec_w, dec_q, rd_q;
  logic             dec_v, rd_v, rd_act, buf_valid, buf_we;
  logic [AW-1:0]    wptr, rptr;

  lb_loop_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .loop_start(loop_start), .loop_len(loop_len),
    .loop_count(loop_count), .fetch_en(fetch_en), .accept(accept),
    .cap_tag(cap_tag), .last_tag(last_tag), .len_q(len_q), .cnt_q(cnt_q)
  );

  lb_fetch_stage #(.IW(IW)) i_fetch (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .instr_in(instr_in),
    .cap_tag(cap_tag), .last_tag(last_tag), .word_q(fq_word),
    .valid_q(decode_en), .cap_q(fq_cap), .last_q(fq_last)
  );

  lb_decode_stage #(.IW(IW), .OPC_W(OPC_W)) i_dec (
    .clk(clk), .rst(rst), .in_v(decode_en), .word(fq_word),
    .dec_w(dec_w), .dec_q(dec_q), .dec_v(dec_v)
  );

  assign buf_we = decode_en & fq_cap;

  lb_replay_buf #(.DEPTH(DEPTH), .CW(CW), .CNT_W(CNT_W)) i_buf (
    .clk(clk), .rst(rst), .clear(accept), .we(buf_we), .we_last(fq_last),
    .wdata(dec_w), .len_q(len_q), .cnt_q(cnt_q), .rd_q(rd_q), .rd_v(rd_v),
    .rd_act(rd_act), .buf_valid(buf_valid), .wptr(wptr), .rptr(rptr)
  );

  lb_out_sel #(.CW(CW)) i_sel (
    .clk(clk), .rst(rst), .rd_v(rd_v), .rd_q(rd_q), .dec_v(dec_v),
    .dec_q(dec_q), .ctrl_out(ctrl_out), .ctrl_valid(ctrl_valid),
    .from_buffer(from_buffer)
  );
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_en,
  input logic             decode_en,
  input logic             ctrl_valid,
  input logic             from_buffer,
  input logic             rd_v,
  input logic             dec_v,
  input logic             rd_act,
  input logic             buf_valid,
  input logic             buf_we,
  input logic [AW-1:0]    wptr,
  input logic [AW-1:0]    rptr,
  input logic [LEN_W-1:0] len_q
);
  // live and stored sources never compete for the selector
  assert_sel_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_v && dec_v));

  // a capture never writes beyond the body length
  assert_capture_in_bounds_R3: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (LEN_W'(wptr) < len_q));

  assert_replay_has_data_R5: assert property (@(posedge clk) disable iff (rst)
    rd_act |-> buf_valid);

  assert_replay_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    rd_act |-> (LEN_W'(rptr) < len_q));

  assert_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_valid |=> ctrl_valid);

  assert_decode_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> !decode_en);

  // a replayed word can only leave while decode sat idle
  assert_replay_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    from_buffer |-> !$past(decode_en, 2));
endmodule

bind loop_replay_frontend lb_checker #(.DEPTH(DEPTH)) i_lb_checker (
  .clk(clk), .rst(rst), .fetch_en(fetch_en), .decode_en(decode_en),
  .ctrl_valid(ctrl_valid), .from_buffer(from_buffer), .rd_v(rd_v),
  .dec_v(dec_v), .rd_act(rd_act), .buf_valid(buf_valid), .buf_we(buf_we),
  .wptr(wptr), .rptr(rptr), .len_q(len_q)
);

// File: tb/test_loop_replay_frontend.sv
module test_loop_replay_frontend;
  localparam int IW = 16, DEPTH = 16, CNT_W = 16, LEN_W = 5, CW = 28;
  localparam int MAIN_CYC = 4000, WATCHDOG = 20000;

  logic clk = 1'b0, rst = 1'b1, loop_start = 1'b0;
  logic [LEN_W-1:0] loop_len = '0;
  logic [CNT_W-1:0] loop_count = '0;
  logic [IW-1:0] instr_in = '0;
  logic fetch_en, decode_en, ctrl_valid, from_buffer;
  logic [CW-1:0] ctrl_out;

  loop_replay_frontend i_loop_replay_frontend (
    .clk(clk), .rst(rst), .loop_start(loop_start), .loop_len(loop_len),
    .loop_count(loop_count), .instr_in(instr_in), .fetch_en(fetch_en),
    .decode_en(decode_en), .ctrl_out(ctrl_out), .ctrl_valid(ctrl_valid),
    .from_buffer(from_buffer)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [IW-1:0] fq[$];
  logic [CW-1:0] eq[$];
  bit            ebq[$];
  string         etq[$];
  int            offq[$];
  string         offtq[$];
  bit  seen_valid = 0, prev_fetch = 1, cur_elig = 0, cur_inject = 0;
  int  off_run = 0, nsamp = 0, dir_idx = 0;
  int  dir_len[6] = '{1, 16, 17, 4, 3, 5};
  int  dir_cnt[6] = '{2, 3, 2, 1, 4, 3};
  bit  dir_inj[6] = '{0, 0, 0, 0, 1, 1};

  function automatic logic [CW-1:0] ref_ctrl(logic [IW-1:0] w);
    logic [15:0] oh;
    oh = 16'd1 << w[15:12];
    return {w[11:0], oh};
  endfunction

  task automatic check(bit ok, string req, string what, longint unsigned act,
                       longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_word(logic [IW-1:0] w, bit fb, string tag);
    eq.push_back(ref_ctrl(w));
    ebq.push_back(fb);
    etq.push_back(tag);
  endtask

  task automatic start_loop(int L, int N, bit inj);
    logic [IW-1:0] body[$];
    bit elig;
    string tag;
    elig = (L >= 1) && (L <= DEPTH) && (N >= 2);
    tag = !elig ? "R7" : ((L == 1 || L == DEPTH) ? "R9" : "R5");
    for (int i = 0; i < L; i++) body.push_back(IW'($urandom));
    for (int p = 0; p < N; p++)
      for (int i = 0; i < L; i++) begin
        push_word(body[i], elig && (p > 0), tag);
        if (!elig || p == 0) fq.push_back(body[i]);
      end
    if (elig) begin
      offq.push_back((N - 1) * L);
      offtq.push_back("R3");
    end
    cur_elig = elig;
    cur_inject = inj;
    instr_in = fq.pop_front();
    loop_start = 1'b1;
    loop_len = LEN_W'(L);
    loop_count = CNT_W'(N);
  endtask

  task automatic stray_start();
    loop_start = 1'b1;
    loop_len = LEN_W'(1 + $urandom % DEPTH);
    loop_count = CNT_W'(2 + $urandom % 3);
    if (offtq.size() > 0) offtq[offtq.size() - 1] = "R8";
  endtask

  task automatic step_drive(bit allow_new);
    loop_start = 1'b0;
    if (fetch_en) begin
      if (fq.size() > 0) begin
        if (cur_elig && cur_inject && ($urandom % 3 == 0)) stray_start();
        instr_in = fq.pop_front();
      end else if (allow_new && dir_idx < 6) begin
        start_loop(dir_len[dir_idx], dir_cnt[dir_idx], dir_inj[dir_idx]);
        dir_idx++;
      end else if (allow_new && ($urandom % 8 == 0)) begin
        start_loop(1 + $urandom % 20, 1 + $urandom % 4, ($urandom % 2) == 1);
      end else begin
        cur_elig = 0;
        instr_in = IW'($urandom);
        push_word(instr_in, 1'b0, "R2");
      end
    end else begin
      instr_in = IW'($urandom);
      if (cur_inject && ($urandom % 4 == 0)) stray_start();
    end
  endtask

  task automatic step_sample();
    nsamp++;
    check(decode_en == prev_fetch, "R4", "decode_en lag", decode_en, prev_fetch);
    if (ctrl_valid) begin
      if (!seen_valid)
        check(nsamp == 3, "R2", "first-word latency", nsamp, 3);
      seen_valid = 1;
      if (eq.size() == 0) begin
        check(0, "R2", "unexpected word", ctrl_out, 0);
      end else begin
        logic [CW-1:0] e;
        bit fb;
        string t;
        e = eq.pop_front();
        fb = ebq.pop_front();
        t = etq.pop_front();
        check(ctrl_out == e, t, "ctrl_out", ctrl_out, e);
        check(from_buffer == fb, t, "from_buffer", from_buffer, fb);
      end
    end else if (seen_valid) begin
      check(0, "R6", "ctrl_valid gap", 0, 1);
    end
    if (!fetch_en) begin
      off_run++;
    end else if (off_run > 0) begin
      if (offq.size() == 0) begin
        check(0, "R7", "unexpected gating run", off_run, 0);
      end else begin
        int eo;
        string t;
        eo = offq.pop_front();
        t = offtq.pop_front();
        check(off_run == eo, t, "gated cycles", off_run, eo);
      end
      off_run = 0;
    end
    prev_fetch = fetch_en;
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(fetch_en == 1'b1, "R1", "fetch_en in reset", fetch_en, 1);
    check(decode_en == 1'b0, "R1", "decode_en in reset", decode_en, 0);
    check(ctrl_valid == 1'b0, "R1", "ctrl_valid in reset", ctrl_valid, 0);
    check(from_buffer == 1'b0, "R1", "from_buffer in reset", from_buffer, 0);
    rst = 1'b0;
    step_drive(1'b1);
    prev_fetch = fetch_en;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      step_sample();
      if (cyc >= MAIN_CYC && fq.size() == 0 && offq.size() == 0 &&
          fetch_en && off_run == 0)
        break;
      if (cyc >= WATCHDOG) begin
        check(0, "R6", "watchdog expired", cyc, WATCHDOG);
        break;
      end
      step_drive(cyc < MAIN_CYC);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule